// File: doc/BRIEF.md
# SPI Interrupt Status Controller

This block gathers the interrupt-worthy events of an SPI controller into a sticky status register. It qualifies them with a per-bit enable register and a single global enable bit, and drives one level-sensitive interrupt line toward the processor. Some events arrive as one-cycle pulses: transmit empty, transmit underrun, receive overrun and transmit half empty. Others are levels that stay high while their condition lasts: receive not empty and receive full.

Software reaches the three registers through a simple register port with separate write and read addresses; reads are combinational. Writing the status register does not use write-one-to-clear. Every 1 in the written word inverts the stored bit, so a handler clears the bits it has just read by writing them back. A level event sets its bit again on every cycle its condition holds, so its bit cannot be cleared until the condition goes away. A soft-clear input returns all three registers to zero.

Top module: `spi_irq_ctrl`

## Requirements
- R1: After rst_n is released, the global enable, status and enable registers all read 0 and irq is low.
- R2: Register byte addresses are global enable 0x1C, status 0x20 and enable 0x28. Any other read address returns 0, and writes to other addresses change none of the three registers.
- R3: A write to the status register replaces each stored bit with its XOR against the written bit.
- R4: Pulse events set status bits that stay set until software toggles them. The bit positions are transmit empty 2, transmit underrun 3, receive overrun 5 and transmit half empty 6.
- R5: While the receive-not-empty level (bit 8) or the receive-full level (bit 4) is high, its status bit is set on every clock. A toggle write to that bit while the level is high leaves it set.
- R6: When an event and a toggle write hit the same status bit in the same cycle, the bit ends up set. Other bits in that write still toggle.
- R7: irq becomes 1 one clock after (status AND enable) is nonzero with the global enable bit set, and otherwise becomes 0 one clock later. In the cycle of the change, irq still shows the previous value.
- R8: Only bit 31 of the global enable register is stored. Its other bits read 0, and clearing bit 31 forces irq low.
- R9: A one-cycle soft_clr pulse zeroes the three registers at that edge, and irq falls one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_clr | input | 1 | Synchronous clear of all three registers |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 32 | Combinational read data |
| ev_tx_empty | input | 1 | Pulse: transmit FIFO drained |
| ev_tx_underrun | input | 1 | Pulse: transmit underrun |
| ev_rx_overrun | input | 1 | Pulse: receive data dropped |
| ev_tx_half | input | 1 | Pulse: transmit FIFO half empty |
| lvl_rx_not_empty | input | 1 | Level: receive FIFO holds data |
| lvl_rx_full | input | 1 | Level: receive FIFO full |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach is a collision: an event and a toggle write land on the same status bit at the same edge, and the write also flips another bit. The stimulus first sets the bit with a pulse. It then drives a second pulse together with a write that toggles both that bit and a neighbour, so a wrong priority shows up either as a cleared event bit or as an untoggled neighbour. The held-level case is reached in a similar way: a level input is kept high while software tries to toggle its bit off, and the bit is checked again after the level drops.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
   // Status bit positions; the event sources decode these positions.
   localparam int unsigned BIT_TX_EMPTY    = 2;
   localparam int unsigned BIT_TX_UNDERRUN = 3;
   localparam int unsigned BIT_RX_FULL     = 4;
   localparam int unsigned BIT_RX_OVERRUN  = 5;
   localparam int unsigned BIT_TX_HALF     = 6;
   localparam int unsigned BIT_RX_NEMPTY   = 8;
   localparam int unsigned BIT_TOP         = 8;

   typedef struct packed {
      logic tx_empty;
      logic tx_underrun;
      logic rx_overrun;
      logic tx_half;
      logic rx_nempty;
      logic rx_full;
   } evt_bundle_t;
endpackage

// File: rtl/spi_irq_evt_map.sv
module spi_irq_evt_map
   import spi_irq_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  evt_bundle_t        evt,
   output logic [DATA_W-1:0]  set_vec
);
   always_comb begin
      set_vec                  = '0;
      set_vec[BIT_TX_EMPTY]    = evt.tx_empty;
      set_vec[BIT_TX_UNDERRUN] = evt.tx_underrun;
      set_vec[BIT_RX_FULL]     = evt.rx_full;
      set_vec[BIT_RX_OVERRUN]  = evt.rx_overrun;
      set_vec[BIT_TX_HALF]     = evt.tx_half;
      set_vec[BIT_RX_NEMPTY]   = evt.rx_nempty;
   end
endmodule

// File: rtl/spi_irq_status_reg.sv
module spi_irq_status_reg #(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tgl_en,
   input  logic [WIDTH-1:0] tgl_data,
   input  logic [WIDTH-1:0] set_vec,
   output logic [WIDTH-1:0] q
);
   // One flop per bit: toggle first, then the event forces the bit on.
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     q[i] <= 1'b0;
         else if (clr)   q[i] <= 1'b0;
         else            q[i] <= (q[i] ^ (tgl_en & tgl_data[i])) | set_vec[i];
      end
   end

   AST_TOGGLE_XOR: assert property (@(posedge clk) disable iff (!rst_n)
      (tgl_en && set_vec == '0 && !clr) |=> (q == $past(q ^ tgl_data))); // R3
   AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_vec != '0) && !clr) |=> ((q & $past(set_vec)) == $past(set_vec))); // R6
   AST_NO_SELF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (!tgl_en && !clr) |=> ((q & ~$past(q) & ~$past(set_vec)) == '0)); // R4
   AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (q == '0)); // R9
endmodule

// File: rtl/spi_irq_plain_reg.sv
module spi_irq_plain_reg #(
   parameter int unsigned      WIDTH = 32,
   parameter logic [WIDTH-1:0] KEEP  = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             we,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   // Only bits named in KEEP get a flop; the rest are tied low.
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (KEEP[i]) begin : g_ff
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q[i] <= 1'b0;
            else if (clr) q[i] <= 1'b0;
            else if (we)  q[i] <= d[i];
         end
      end else begin : g_tie
         assign q[i] = 1'b0;
      end
   end

   AST_REG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (q == '0)); // R9
   AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!we && !clr) |=> $stable(q)); // R2
endmodule

// File: rtl/spi_irq_out.sv
module spi_irq_out #(
   parameter int unsigned WIDTH   = 32,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] status,
   input  logic [WIDTH-1:0] enable,
   input  logic             gate,
   output logic             irq
);
   logic hit;
   assign hit = (|(status & enable)) & gate;

   if (OUT_REG) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= hit;
      end
      assign irq = irq_q;

      AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
         !gate |=> !irq); // R8
      AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
         ((status & enable) == '0) |=> !irq); // R7
      AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
         (gate && ((status & enable) != '0)) |=> irq); // R7
   end else begin : g_comb
      assign irq = hit;
   end
endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
   import spi_irq_pkg::*;
#(
   parameter int unsigned          DATA_W   = 32,
   parameter int unsigned          ADDR_W   = 8,
   parameter logic [ADDR_W-1:0]    GIE_ADDR = 8'h1C,
   parameter logic [ADDR_W-1:0]    ISR_ADDR = 8'h20,
   parameter logic [ADDR_W-1:0]    IER_ADDR = 8'h28,
   parameter int unsigned          GIE_BIT  = DATA_W - 1,
   parameter bit                   OUT_REG  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_clr,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              ev_tx_empty,
   input  logic              ev_tx_underrun,
   input  logic              ev_rx_overrun,
   input  logic              ev_tx_half,
   input  logic              lvl_rx_not_empty,
   input  logic              lvl_rx_full,
   output logic              irq
);
   localparam logic [DATA_W-1:0] GIE_KEEP = DATA_W'(1) << GIE_BIT;

   if (DATA_W <= BIT_TOP) begin : g_chk_width
      $error("DATA_W too narrow for the status bit map");
   end
   if (GIE_BIT >= DATA_W) begin : g_chk_gie
      $error("GIE_BIT outside the data word");
   end
   if (GIE_ADDR == ISR_ADDR || GIE_ADDR == IER_ADDR || ISR_ADDR == IER_ADDR) begin : g_chk_addr
      $error("register addresses must differ");
   end

   evt_bundle_t       evt;
   logic [DATA_W-1:0] set_vec;
   logic [DATA_W-1:0] status_q;
   logic [DATA_W-1:0] enable_q;
   logic [DATA_W-1:0] gie_q;
   logic              we_gie, we_isr, we_ier;

   assign evt = '{tx_empty: ev_tx_empty, tx_underrun: ev_tx_underrun,
                  rx_overrun: ev_rx_overrun, tx_half: ev_tx_half,
                  rx_nempty: lvl_rx_not_empty, rx_full: lvl_rx_full};

   assign we_gie = wr_en && (wr_addr == GIE_ADDR);
   assign we_isr = wr_en && (wr_addr == ISR_ADDR);
   assign we_ier = wr_en && (wr_addr == IER_ADDR);

   spi_irq_evt_map #(.DATA_W(DATA_W)) u_map (
      .evt     (evt),
      .set_vec (set_vec)
   );

   spi_irq_status_reg #(.WIDTH(DATA_W)) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (soft_clr),
      .tgl_en   (we_isr),
      .tgl_data (wr_data),
      .set_vec  (set_vec),
      .q        (status_q)
   );

   spi_irq_plain_reg #(.WIDTH(DATA_W), .KEEP('1)) u_enable (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (soft_clr),
      .we    (we_ier),
      .d     (wr_data),
      .q     (enable_q)
   );

   spi_irq_plain_reg #(.WIDTH(DATA_W), .KEEP(GIE_KEEP)) u_gie (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (soft_clr),
      .we    (we_gie),
      .d     (wr_data),
      .q     (gie_q)
   );

   spi_irq_out #(.WIDTH(DATA_W), .OUT_REG(OUT_REG)) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .status (status_q),
      .enable (enable_q),
      .gate   (gie_q[GIE_BIT]),
      .irq    (irq)
   );

   always_comb begin
      unique case (rd_addr)
         GIE_ADDR: rd_data = gie_q;
         ISR_ADDR: rd_data = status_q;
         IER_ADDR: rd_data = enable_q;
         default:  rd_data = '0;
      endcase
   end

   AST_LEVEL_RXNE: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_rx_not_empty && !soft_clr) |=> status_q[BIT_RX_NEMPTY]); // R5
   AST_LEVEL_RXFULL: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_rx_full && !soft_clr) |=> status_q[BIT_RX_FULL]); // R5
endmodule

// File: tb/sim_spi_irq_ctrl.sv
`timescale 1ns/1ps
module sim_spi_irq_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        soft_clr = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = 8'h0;
   logic [31:0] wr_data = 32'h0;
   logic [7:0]  rd_addr = 8'h0;
   logic [31:0] rd_data;
   logic        ev_tx_empty = 1'b0, ev_tx_underrun = 1'b0, ev_rx_overrun = 1'b0, ev_tx_half = 1'b0;
   logic        lvl_rx_not_empty = 1'b0, lvl_rx_full = 1'b0;
   logic        irq;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   localparam logic [7:0] A_GIE = 8'h1C, A_ISR = 8'h20, A_IER = 8'h28;

   typedef struct {
      bit          is_irq;
      logic [7:0]  addr;
      logic [31:0] exp;
      string       tag;
   } item_t;
   item_t sb[$];

   always #2.5 clk = ~clk;

   spi_irq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .ev_tx_empty(ev_tx_empty), .ev_tx_underrun(ev_tx_underrun),
      .ev_rx_overrun(ev_rx_overrun), .ev_tx_half(ev_tx_half),
      .lvl_rx_not_empty(lvl_rx_not_empty), .lvl_rx_full(lvl_rx_full),
      .irq(irq)
   );

   // Monitor: one expected item per falling edge.
   item_t it;
   logic [31:0] act;
   always begin
      @(negedge clk);
      if (sb.size() > 0) begin
         it = sb.pop_front();
         if (!it.is_irq) rd_addr = it.addr;
         #1;
         act = it.is_irq ? {31'h0, irq} : rd_data;
         checks++;
         if (act !== it.exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
         end
      end
   end

   task automatic exp_rd(input logic [7:0] a, input logic [31:0] e, input string t);
      item_t x;
      x.is_irq = 1'b0; x.addr = a; x.exp = e; x.tag = t;
      sb.push_back(x);
   endtask

   task automatic exp_irq(input logic e, input string t);
      item_t x;
      x.is_irq = 1'b1; x.addr = 8'h0; x.exp = {31'h0, e}; x.tag = t;
      sb.push_back(x);
   endtask

   task automatic drain();
      wait (sb.size() == 0);
   endtask

   task automatic settle();
      @(posedge clk); #1;
   endtask

   // mask bits: [0] tx_empty, [1] tx_underrun, [2] rx_overrun, [3] tx_half
   task automatic op(input bit w, input logic [7:0] a, input logic [31:0] d, input logic [3:0] m);
      @(posedge clk); #1;
      wr_en = w; wr_addr = a; wr_data = d;
      {ev_tx_half, ev_rx_overrun, ev_tx_underrun, ev_tx_empty} = m;
      @(posedge clk); #1;
      wr_en = 1'b0;
      {ev_tx_half, ev_rx_overrun, ev_tx_underrun, ev_tx_empty} = 4'h0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      op(1'b1, a, d, 4'h0);
   endtask

   task automatic pulse(input logic [3:0] m);
      op(1'b0, 8'h0, 32'h0, m);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      settle();
      // R1
      exp_rd(A_GIE, 32'h0, "R1 gie after reset");
      exp_rd(A_ISR, 32'h0, "R1 status after reset");
      exp_rd(A_IER, 32'h0, "R1 enable after reset");
      exp_irq(1'b0, "R1 irq after reset");
      drain();

      // R8: only bit 31 kept
      wr(A_GIE, 32'hFFFF_FFFF);
      exp_rd(A_GIE, 32'h8000_0000, "R8 gie keeps bit31 only");
      drain();
      wr(A_GIE, 32'h7FFF_FFFF);
      exp_rd(A_GIE, 32'h0, "R8 gie low bits ignored");
      drain();

      // R2: other addresses
      wr(A_IER, 32'h0000_0123);
      wr(8'h24, 32'hFFFF_FFFF);
      exp_rd(8'h24, 32'h0, "R2 unmapped read zero");
      exp_rd(A_IER, 32'h0000_0123, "R2 enable unchanged by stray write");
      exp_rd(A_ISR, 32'h0, "R2 status unchanged by stray write");
      exp_rd(A_GIE, 32'h0, "R2 gie unchanged by stray write");
      drain();
      wr(A_IER, 32'h0);

      // R3: toggle
      wr(A_ISR, 32'h0000_00A5);
      exp_rd(A_ISR, 32'h0000_00A5, "R3 toggle from zero");
      drain();
      wr(A_ISR, 32'h0000_00FF);
      exp_rd(A_ISR, 32'h0000_005A, "R3 toggle inverts");
      drain();
      wr(A_ISR, 32'h0000_005A);
      exp_rd(A_ISR, 32'h0, "R3 toggle clears");
      drain();

      // R4: pulse events sticky
      pulse(4'b0001);
      exp_rd(A_ISR, 32'h0000_0004, "R4 tx empty bit2");
      drain();
      pulse(4'b0010);
      exp_rd(A_ISR, 32'h0000_000C, "R4 underrun bit3");
      drain();
      pulse(4'b0100);
      exp_rd(A_ISR, 32'h0000_002C, "R4 overrun bit5");
      drain();
      pulse(4'b1000);
      settle();
      exp_rd(A_ISR, 32'h0000_006C, "R4 half empty bit6 sticky");
      drain();
      wr(A_ISR, 32'h0000_006C);
      exp_rd(A_ISR, 32'h0, "R4 cleared by toggle");
      drain();

      // R5: levels
      lvl_rx_not_empty = 1'b1;
      settle();
      exp_rd(A_ISR, 32'h0000_0100, "R5 rx not empty bit8");
      drain();
      wr(A_ISR, 32'h0000_0100);
      exp_rd(A_ISR, 32'h0000_0100, "R5 level defeats toggle");
      drain();
      lvl_rx_full = 1'b1;
      settle();
      exp_rd(A_ISR, 32'h0000_0110, "R5 rx full bit4");
      drain();
      lvl_rx_not_empty = 1'b0; lvl_rx_full = 1'b0;
      settle(); settle();
      exp_rd(A_ISR, 32'h0000_0110, "R5 bits stay after level drops");
      drain();
      wr(A_ISR, 32'h0000_0110);
      exp_rd(A_ISR, 32'h0, "R5 cleared once level gone");
      drain();

      // R6: collision
      pulse(4'b0001);
      op(1'b1, A_ISR, 32'h0000_0014, 4'b0001);
      exp_rd(A_ISR, 32'h0000_0014, "R6 event wins, neighbour toggles");
      drain();
      wr(A_ISR, 32'h0000_0014);

      // R7 / R8: interrupt output
      wr(A_IER, 32'h0000_0008);
      wr(A_GIE, 32'h8000_0000);
      settle();
      exp_irq(1'b0, "R7 no status no irq");
      drain();
      pulse(4'b0010);
      settle();
      exp_irq(1'b1, "R7 enabled status raises irq");
      drain();
      wr(A_GIE, 32'h0);
      exp_irq(1'b1, "R7 irq one clock late");
      exp_irq(1'b0, "R8 global disable drops irq");
      drain();
      wr(A_GIE, 32'h8000_0000);
      settle();
      exp_irq(1'b1, "R8 global enable restores irq");
      drain();
      wr(A_IER, 32'h0000_0004);
      exp_irq(1'b1, "R7 mask change latency");
      exp_irq(1'b0, "R7 masked status no irq");
      drain();
      wr(A_IER, 32'h0000_0008);
      settle();
      exp_irq(1'b1, "R7 unmasked again");
      drain();

      // R9: soft clear
      @(posedge clk); #1 soft_clr = 1'b1;
      @(posedge clk); #1 soft_clr = 1'b0;
      exp_irq(1'b1, "R9 irq still high in clear cycle");
      exp_irq(1'b0, "R9 irq falls after clear");
      exp_rd(A_GIE, 32'h0, "R9 gie cleared");
      exp_rd(A_ISR, 32'h0, "R9 status cleared");
      exp_rd(A_IER, 32'h0, "R9 enable cleared");
      drain();

      settle();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #1000000;
      if (!done) begin
         done = 1'b1;
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule